// File: doc/BRIEF.md
# Processor Mode Banked Register Switch

This block keeps a processor's status word, whose lowest five bits select the operating mode. It also keeps the registers that each mode owns privately: a stack pointer, a link register and a saved status word for every mode bank, plus a second set of general registers 8 to 12 used only in fast-interrupt mode. A status write carries a data word and one enable bit per byte lane. When that write moves the mode field to a new legal mode, the block parks the live private registers in the outgoing mode's bank and brings in the incoming mode's copies, all on one clock edge.

A write that asks for an unknown mode leaves the mode field, and therefore every bank, as it was. The other enabled bits of the same write still land. A separate port reads or writes the stack pointer of any named mode. It reaches the live register when the named mode is the current one, and the parked copy otherwise. A small write port loads the live registers, standing in for the register file's writeback.

Top module: `mode_bank_switch`

## Requirements
- R1: After reset the status word is 0x00000013, which is supervisor mode with all other bits zero, and every live register, bank slot and fast-interrupt register reads zero.
- R2: A status write replaces bits [8i+7:8i] with the written data for each set mask bit i and keeps every other bit. The new value is visible after the next rising clock edge.
- R3: Only the mode codes 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined and 0x1F system are legal. A write with lane 0 enabled that names any other code keeps status bits [4:0] unchanged and still writes all other enabled bits.
- R4: A mode switch happens only when lane 0 is enabled, the written bits [4:0] differ from the current ones, and the new code is legal. On that edge the live stack pointer, link register and saved status word are stored into the old mode's bank, and the new mode's bank values become live.
- R5: User and system modes share one bank, so switching between them keeps the live stack pointer. Every other legal mode has a bank of its own.
- R6: Entering fast-interrupt mode swaps live registers 8 to 12 with the fast-interrupt set, and leaving it swaps them back. Switches between two other modes leave registers 8 to 12 unchanged.
- R7: A banked access with bk_en high names a mode in bk_mode. If that mode is the current mode, it reads or writes the live stack pointer. Otherwise it reads or writes that mode's bank slot. The read is combinational, and a write is visible after the next edge.
- R8: A banked access that names an illegal mode raises bk_err in the same cycle, returns zero on bk_rdata, and changes no register.
- R9: In a cycle with sr_wr_en high, the live-register write port and any banked write are ignored.
- R10: The live write port loads, on the next edge, register 8+lv_wr_sel for select codes 0 to 4, the stack pointer for code 5, the link register for code 6 and the saved status word for code 7. Register 8+i appears at live_hi[32i+31:32i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_wr_en | input | 1 | Status write strobe |
| sr_wr_data | input | DATA_W | Status write data |
| sr_wr_mask | input | DATA_W/8 | Byte-lane enables for the status write |
| sr_q | output | DATA_W | Current status word; bits [4:0] are the mode |
| lv_wr_en | input | 1 | Live register write strobe |
| lv_wr_sel | input | 3 | Live register select (R10 codes) |
| lv_wr_data | input | DATA_W | Live register write data |
| live_sp | output | DATA_W | Live stack pointer |
| live_lr | output | DATA_W | Live link register |
| live_spsr | output | DATA_W | Live saved status word |
| live_hi | output | 5*DATA_W | Live registers 8 to 12, register 8 in the low word |
| bk_en | input | 1 | Banked stack-pointer access strobe |
| bk_we | input | 1 | Banked access is a write |
| bk_mode | input | 5 | Mode whose stack pointer is accessed |
| bk_wdata | input | DATA_W | Banked write data |
| bk_rdata | output | DATA_W | Banked read data (combinational) |
| bk_err | output | 1 | Banked access names an illegal mode |

## Verification
Every register result (the status word, the live registers and the parked banks) is due one rising edge after the stimulus. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and compares the outputs at that same falling edge. The banked read data and bk_err are combinational, so they are compared one time unit after bk_mode is applied, inside the same low clock phase. Parked bank contents cannot be observed directly, so they are checked either by reading them through the banked port or by switching back into the mode and comparing the live registers.

// File: rtl/mbs_pkg.sv
// Package: mode codes and sizes shared by the banked register switch.
// Assumes a 5-bit mode field in status bits [4:0].
package mbs_pkg;
    localparam int MODE_W    = 5;
    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = 3;
    localparam int HI_REGS   = 5;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [BANK_W-1:0] bank_t;

    localparam mode_t MODE_USR = 5'h10;
    localparam mode_t MODE_FIQ = 5'h11;
    localparam mode_t MODE_IRQ = 5'h12;
    localparam mode_t MODE_SVC = 5'h13;
    localparam mode_t MODE_ABT = 5'h17;
    localparam mode_t MODE_UND = 5'h1B;
    localparam mode_t MODE_SYS = 5'h1F;

    // Live write port select codes at or above this value address sp/lr/spsr.
    localparam logic [2:0] SEL_SP   = 3'd5;
    localparam logic [2:0] SEL_LR   = 3'd6;
    localparam logic [2:0] SEL_SPSR = 3'd7;
endpackage

// File: rtl/mbs_mode_decode.sv
// Module: mbs_mode_decode
// Purpose: classify a mode code as legal or not and give its bank index.
// Assumes: purely combinational; the bank index is 0 for illegal codes.
module mbs_mode_decode
    import mbs_pkg::*;
(
    input  mode_t mode,
    output logic  legal,
    output bank_t bank
);
    // Map each legal mode to its bank; user and system share bank 0.
    always_comb begin
        legal = 1'b1;
        bank  = '0;
        case (mode)
            MODE_USR, MODE_SYS: bank = 3'd0;
            MODE_SVC:           bank = 3'd1;
            MODE_ABT:           bank = 3'd2;
            MODE_UND:           bank = 3'd3;
            MODE_IRQ:           bank = 3'd4;
            MODE_FIQ:           bank = 3'd5;
            default:            legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbs_status_ctl.sv
// Module: mbs_status_ctl
// Purpose: hold the status word, apply byte-masked writes, and detect a
//          legal mode switch. An illegal requested mode strips the mode bits
//          from the write mask so only the other enabled bits change.
// Assumes: DATA_W is a multiple of 8 and at least 8.
module mbs_status_ctl
    import mbs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [DATA_W/8-1:0] wr_mask,
    output logic [DATA_W-1:0]   sr_q,
    output mode_t               cur_mode,
    output mode_t               req_mode,
    output logic                switch_go
);
    localparam int LANES = DATA_W / 8;
    localparam logic [DATA_W-1:0] RESET_SR = DATA_W'(MODE_SVC);
    localparam logic [DATA_W-1:0] MODE_BITS = DATA_W'({MODE_W{1'b1}});

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] eff_mask;
    logic              req_legal;
    bank_t             req_bank_unused;
    logic              mode_req;

    // Expand one enable bit per byte lane into a bit mask.
    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_lane
            assign lane_mask[gi*8 +: 8] = {8{wr_mask[gi]}};
        end
    endgenerate

    assign cur_mode = sr_q[MODE_W-1:0];
    assign req_mode = wr_data[MODE_W-1:0];

    mbs_mode_decode u_req_dec (
        .mode  (req_mode),
        .legal (req_legal),
        .bank  (req_bank_unused)
    );

    // A mode change is requested only when lane 0 is on and the field differs.
    assign mode_req  = wr_en && wr_mask[0] && (req_mode != cur_mode);
    assign switch_go = mode_req && req_legal;

    // Drop the mode bits from the mask when the requested mode is illegal.
    always_comb begin
        eff_mask = lane_mask;
        if (mode_req && !req_legal) begin
            eff_mask = lane_mask & ~MODE_BITS;
        end
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= RESET_SR;
        end else if (wr_en) begin
            sr_q <= (sr_q & ~eff_mask) | (wr_data & eff_mask);
        end
    end
endmodule

// File: rtl/mbs_bank_file.sv
// Module: mbs_bank_file
// Purpose: live stack pointer, link register and saved status word, plus one
//          parked copy of each per mode bank; save/load on a mode switch.
// Assumes: switch_go is never high with old_mode equal to new_mode; write
//          strobes are already qualified by the caller.
module mbs_bank_file
    import mbs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              switch_go,
    input  bank_t             old_bank,
    input  bank_t             new_bank,
    input  logic              lv_we,
    input  logic [2:0]        lv_sel,
    input  logic [DATA_W-1:0] lv_wdata,
    input  logic              bk_live_we,
    input  logic              bk_bank_we,
    input  bank_t             bk_bank,
    input  logic [DATA_W-1:0] bk_wdata,
    output logic [DATA_W-1:0] live_sp,
    output logic [DATA_W-1:0] live_lr,
    output logic [DATA_W-1:0] live_spsr,
    output logic [DATA_W-1:0] bk_bank_sp
);
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_sp;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_lr;
    logic [NUM_BANKS-1:0][DATA_W-1:0] bank_spsr;
    logic                             same_bank;

    assign bk_bank_sp = bank_sp[bk_bank];
    assign same_bank  = (old_bank == new_bank);

    // Parked bank storage: save outgoing copies, or take a banked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                bank_sp[b]   <= '0;
                bank_lr[b]   <= '0;
                bank_spsr[b] <= '0;
            end
        end else if (switch_go) begin
            bank_sp[old_bank]   <= live_sp;
            bank_lr[old_bank]   <= live_lr;
            bank_spsr[old_bank] <= live_spsr;
        end else if (bk_bank_we) begin
            bank_sp[bk_bank] <= bk_wdata;
        end
    end

    // Live registers: load incoming copies, or take a direct/banked write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_sp   <= '0;
            live_lr   <= '0;
            live_spsr <= '0;
        end else if (switch_go) begin
            if (!same_bank) begin
                live_sp   <= bank_sp[new_bank];
                live_lr   <= bank_lr[new_bank];
                live_spsr <= bank_spsr[new_bank];
            end
        end else begin
            if (lv_we) begin
                case (lv_sel)
                    SEL_SP:   live_sp   <= lv_wdata;
                    SEL_LR:   live_lr   <= lv_wdata;
                    SEL_SPSR: live_spsr <= lv_wdata;
                    default:  ;
                endcase
            end
            if (bk_live_we) begin
                live_sp <= bk_wdata;
            end
        end
    end
endmodule

// File: rtl/mbs_fiq_swap.sv
// Module: mbs_fiq_swap
// Purpose: live registers 8..12 with a normal shadow set and a fast-interrupt
//          set; swapped when the mode enters or leaves fast-interrupt mode.
// Assumes: enter and leave are never both high.
module mbs_fiq_swap
    import mbs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            switch_go,
    input  logic                            enter_fiq,
    input  logic                            leave_fiq,
    input  logic                            hi_we,
    input  logic [2:0]                      hi_idx,
    input  logic [DATA_W-1:0]               hi_wdata,
    output logic [HI_REGS-1:0][DATA_W-1:0]  live_hi
);
    logic [HI_REGS-1:0][DATA_W-1:0] norm_hi;
    logic [HI_REGS-1:0][DATA_W-1:0] fiq_hi;

    // Swap sets across the fast-interrupt boundary, else take a live write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_hi <= '0;
            norm_hi <= '0;
            fiq_hi  <= '0;
        end else if (switch_go && enter_fiq) begin
            norm_hi <= live_hi;
            live_hi <= fiq_hi;
        end else if (switch_go && leave_fiq) begin
            fiq_hi  <= live_hi;
            live_hi <= norm_hi;
        end else if (!switch_go && hi_we) begin
            live_hi[hi_idx] <= hi_wdata;
        end
    end
endmodule

// File: rtl/mode_bank_switch.sv
// Module: mode_bank_switch (top)
// Purpose: status word with mode field, per-mode banked sp/lr/spsr, the
//          fast-interrupt register set, and indirect banked sp access.
// Assumes: a status write cycle takes priority over the live write port and
//          banked writes, which are dropped in that cycle.
module mode_bank_switch
    import mbs_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sr_wr_en,
    input  logic [DATA_W-1:0]           sr_wr_data,
    input  logic [DATA_W/8-1:0]         sr_wr_mask,
    output logic [DATA_W-1:0]           sr_q,
    input  logic                        lv_wr_en,
    input  logic [2:0]                  lv_wr_sel,
    input  logic [DATA_W-1:0]           lv_wr_data,
    output logic [DATA_W-1:0]           live_sp,
    output logic [DATA_W-1:0]           live_lr,
    output logic [DATA_W-1:0]           live_spsr,
    output logic [5*DATA_W-1:0]         live_hi,
    input  logic                        bk_en,
    input  logic                        bk_we,
    input  logic [4:0]                  bk_mode,
    input  logic [DATA_W-1:0]           bk_wdata,
    output logic [DATA_W-1:0]           bk_rdata,
    output logic                        bk_err
);
    mode_t cur_mode;
    mode_t req_mode;
    logic  switch_go;
    logic  cur_legal_unused;
    bank_t cur_bank;
    logic  new_legal_unused;
    bank_t new_bank;
    logic  bk_legal;
    bank_t bk_bank;
    logic  lv_ok;
    logic  bk_is_cur;
    logic  bk_wr_ok;
    logic [DATA_W-1:0] bk_bank_sp;
    logic [HI_REGS-1:0][DATA_W-1:0] hi_regs;

    mbs_status_ctl #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sr_wr_en),
        .wr_data   (sr_wr_data),
        .wr_mask   (sr_wr_mask),
        .sr_q      (sr_q),
        .cur_mode  (cur_mode),
        .req_mode  (req_mode),
        .switch_go (switch_go)
    );

    mbs_mode_decode u_cur_dec (.mode(cur_mode), .legal(cur_legal_unused), .bank(cur_bank));
    mbs_mode_decode u_new_dec (.mode(req_mode), .legal(new_legal_unused), .bank(new_bank));
    mbs_mode_decode u_bk_dec  (.mode(bk_mode),  .legal(bk_legal),         .bank(bk_bank));

    // Qualify the side ports: a status write cycle blocks them.
    assign lv_ok     = lv_wr_en && !sr_wr_en;
    assign bk_is_cur = (bk_mode == cur_mode);
    assign bk_wr_ok  = bk_en && bk_we && bk_legal && !sr_wr_en;
    assign bk_err    = bk_en && !bk_legal;

    // Banked read: live value for the current mode, parked copy otherwise.
    always_comb begin
        bk_rdata = '0;
        if (bk_en && bk_legal) begin
            bk_rdata = bk_is_cur ? live_sp : bk_bank_sp;
        end
    end

    mbs_bank_file #(.DATA_W(DATA_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .switch_go  (switch_go),
        .old_bank   (cur_bank),
        .new_bank   (new_bank),
        .lv_we      (lv_ok && (lv_wr_sel >= SEL_SP)),
        .lv_sel     (lv_wr_sel),
        .lv_wdata   (lv_wr_data),
        .bk_live_we (bk_wr_ok && bk_is_cur),
        .bk_bank_we (bk_wr_ok && !bk_is_cur),
        .bk_bank    (bk_bank),
        .bk_wdata   (bk_wdata),
        .live_sp    (live_sp),
        .live_lr    (live_lr),
        .live_spsr  (live_spsr),
        .bk_bank_sp (bk_bank_sp)
    );

    mbs_fiq_swap #(.DATA_W(DATA_W)) u_fiq (
        .clk       (clk),
        .rst_n     (rst_n),
        .switch_go (switch_go),
        .enter_fiq (req_mode == MODE_FIQ),
        .leave_fiq (cur_mode == MODE_FIQ),
        .hi_we     (lv_ok && (lv_wr_sel < SEL_SP)),
        .hi_idx    (lv_wr_sel),
        .hi_wdata  (lv_wr_data),
        .live_hi   (hi_regs)
    );

    assign live_hi = hi_regs;
endmodule

// File: rtl/mbs_checker.sv
// Module: mbs_checker
// Purpose: temporal properties of mode_bank_switch, seen from its ports.
// Assumes: bound to every instance of mode_bank_switch.
module mbs_checker #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sr_wr_en,
    input logic [DATA_W-1:0]   sr_wr_data,
    input logic [DATA_W/8-1:0] sr_wr_mask,
    input logic [DATA_W-1:0]   sr_q,
    input logic                lv_wr_en,
    input logic [DATA_W-1:0]   live_sp,
    input logic [DATA_W-1:0]   live_lr,
    input logic [DATA_W-1:0]   live_spsr,
    input logic [5*DATA_W-1:0] live_hi,
    input logic                bk_en,
    input logic                bk_we,
    input logic [DATA_W-1:0]   bk_rdata,
    input logic                bk_err
);
    // Independent list of the legal mode codes.
    function automatic logic mode_ok(input logic [4:0] m);
        return (m == 5'h10) || (m == 5'h11) || (m == 5'h12) || (m == 5'h13) ||
               (m == 5'h17) || (m == 5'h1B) || (m == 5'h1F);
    endfunction

    AST_MODE_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ok(sr_q[4:0])); // R3

    AST_ILLEGAL_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en && sr_wr_mask[0] && !mode_ok(sr_wr_data[4:0])
        |=> sr_q[4:0] == $past(sr_q[4:0])); // R3

    AST_LEGAL_MODE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en && sr_wr_mask[0] && mode_ok(sr_wr_data[4:0])
        |=> sr_q[4:0] == $past(sr_wr_data[4:0])); // R4

    AST_NONFIQ_SWITCH_HI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en && sr_wr_mask[0] && sr_wr_data[4:0] != 5'h11 && sr_q[4:0] != 5'h11
        |=> $stable(live_hi)); // R6

    AST_BK_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bk_err |-> bk_rdata == '0); // R8

    AST_BK_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bk_en && bk_we && bk_err && !lv_wr_en && !sr_wr_en
        |=> $stable(live_sp)); // R8

    AST_IDLE_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_en && !lv_wr_en && !(bk_en && bk_we)
        |=> $stable(sr_q) && $stable(live_sp) && $stable(live_lr) && $stable(live_hi)); // R2

    AST_SR_CYCLE_BLOCKS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_en && !(sr_wr_mask[0] && sr_wr_data[4:0] != sr_q[4:0])
        |=> $stable(live_sp) && $stable(live_lr) && $stable(live_spsr) && $stable(live_hi)); // R9
endmodule

bind mode_bank_switch mbs_checker #(.DATA_W(DATA_W)) u_mbs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_wr_en   (sr_wr_en),
    .sr_wr_data (sr_wr_data),
    .sr_wr_mask (sr_wr_mask),
    .sr_q       (sr_q),
    .lv_wr_en   (lv_wr_en),
    .live_sp    (live_sp),
    .live_lr    (live_lr),
    .live_spsr  (live_spsr),
    .live_hi    (live_hi),
    .bk_en      (bk_en),
    .bk_we      (bk_we),
    .bk_rdata   (bk_rdata),
    .bk_err     (bk_err)
);

// File: tb/tb_mode_bank_switch.sv
module tb_mode_bank_switch;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int NVEC = 8;

    // Vector: {write data, lane mask, expected status word after the edge}
    localparam logic [67:0] VEC [NVEC] = '{
        {32'hA5000011, 4'b1001, 32'hA5000011},
        {32'h000000FF, 4'b0001, 32'hA50000FF},
        {32'h00003C05, 4'b0011, 32'hA5003C1F},
        {32'h12345617, 4'b0100, 32'hA5343C1F},
        {32'h00000017, 4'b0000, 32'hA5343C1F},
        {32'hFFFFFFF7, 4'b1111, 32'hFFFFFFF7},
        {32'h0000001C, 4'b0001, 32'hFFFFFF17},
        {32'h00000013, 4'b0001, 32'hFFFFFF13}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sr_wr_en = 1'b0;
    logic [W-1:0] sr_wr_data = '0;
    logic [3:0]   sr_wr_mask = '0;
    logic [W-1:0] sr_q;
    logic         lv_wr_en = 1'b0;
    logic [2:0]   lv_wr_sel = '0;
    logic [W-1:0] lv_wr_data = '0;
    logic [W-1:0] live_sp, live_lr, live_spsr;
    logic [5*W-1:0] live_hi;
    logic         bk_en = 1'b0;
    logic         bk_we = 1'b0;
    logic [4:0]   bk_mode = '0;
    logic [W-1:0] bk_wdata = '0;
    logic [W-1:0] bk_rdata;
    logic         bk_err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_bank_switch #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_wr_mask(sr_wr_mask), .sr_q(sr_q),
        .lv_wr_en(lv_wr_en), .lv_wr_sel(lv_wr_sel), .lv_wr_data(lv_wr_data),
        .live_sp(live_sp), .live_lr(live_lr), .live_spsr(live_spsr), .live_hi(live_hi),
        .bk_en(bk_en), .bk_we(bk_we), .bk_mode(bk_mode), .bk_wdata(bk_wdata),
        .bk_rdata(bk_rdata), .bk_err(bk_err)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic sr_write(input logic [W-1:0] d, input logic [3:0] m);
        @(negedge clk); sr_wr_en = 1'b1; sr_wr_data = d; sr_wr_mask = m;
        @(negedge clk); sr_wr_en = 1'b0; sr_wr_mask = '0;
    endtask

    task automatic lv_write(input logic [2:0] s, input logic [W-1:0] d);
        @(negedge clk); lv_wr_en = 1'b1; lv_wr_sel = s; lv_wr_data = d;
        @(negedge clk); lv_wr_en = 1'b0;
    endtask

    task automatic bk_write(input logic [4:0] md, input logic [W-1:0] d);
        @(negedge clk); bk_en = 1'b1; bk_we = 1'b1; bk_mode = md; bk_wdata = d;
        @(negedge clk); bk_en = 1'b0; bk_we = 1'b0;
    endtask

    task automatic bk_read(input logic [4:0] md, output logic [W-1:0] d, output logic e);
        @(negedge clk); bk_en = 1'b1; bk_we = 1'b0; bk_mode = md;
        #1; d = bk_rdata; e = bk_err;
        bk_en = 1'b0;
    endtask

    function automatic logic [W-1:0] hi(input int i);
        return live_hi[i*W +: W];
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] rd;
        logic         er;
        do_reset();
        // R1 reset state
        chk("R1 status", sr_q, 32'h00000013);
        chk("R1 sp", live_sp, '0);
        chk("R1 lr", live_lr, '0);
        chk("R1 spsr", live_spsr, '0);
        chk("R1 hi8", hi(0), '0);

        // R2 / R3 / R4: table of masked status writes
        for (int i = 0; i < NVEC; i++) begin
            sr_write(VEC[i][67:36], VEC[i][35:32]);
            chk($sformatf("R2 R3 vector %0d", i), sr_q, VEC[i][31:0]);
        end

        do_reset();
        chk("R1 status after re-reset", sr_q, 32'h00000013);

        // R10 live writes
        lv_write(3'd5, 32'h1111);
        lv_write(3'd6, 32'h2222);
        lv_write(3'd7, 32'h3333);
        chk("R10 sp", live_sp, 32'h1111);
        chk("R10 lr", live_lr, 32'h2222);
        chk("R10 spsr", live_spsr, 32'h3333);

        // R4 switch to IRQ loads empty bank, back to supervisor restores
        sr_write(32'h12, 4'b0001);
        chk("R4 mode irq", sr_q, 32'h12);
        chk("R4 irq sp", live_sp, '0);
        chk("R4 irq lr", live_lr, '0);
        chk("R4 irq spsr", live_spsr, '0);
        lv_write(3'd5, 32'hAAAA);
        sr_write(32'h13, 4'b0001);
        chk("R4 svc sp restored", live_sp, 32'h1111);
        chk("R4 svc lr restored", live_lr, 32'h2222);
        chk("R4 svc spsr restored", live_spsr, 32'h3333);

        // R7 banked access
        bk_read(5'h12, rd, er);
        chk("R7 read other bank", rd, 32'hAAAA);
        chk("R7 no err", {31'b0, er}, 32'h0);
        bk_read(5'h13, rd, er);
        chk("R7 read current=live", rd, 32'h1111);
        bk_write(5'h12, 32'h5555);
        chk("R7 other-bank write leaves live", live_sp, 32'h1111);
        bk_read(5'h12, rd, er);
        chk("R7 other-bank write", rd, 32'h5555);
        bk_write(5'h13, 32'h7777);
        chk("R7 current write hits live", live_sp, 32'h7777);

        // R8 illegal banked mode
        bk_read(5'h00, rd, er);
        chk("R8 err flag", {31'b0, er}, 32'h1);
        chk("R8 read zero", rd, '0);
        bk_write(5'h1A, 32'h9999);
        chk("R8 live unchanged", live_sp, 32'h7777);
        bk_read(5'h12, rd, er);
        chk("R8 irq bank unchanged", rd, 32'h5555);
        bk_read(5'h17, rd, er);
        chk("R8 abt bank unchanged", rd, '0);

        // R5 user/system shared bank
        sr_write(32'h10, 4'b0001);
        chk("R5 usr sp", live_sp, '0);
        lv_write(3'd5, 32'hBEEF);
        sr_write(32'h1F, 4'b0001);
        chk("R5 sys keeps usr sp", live_sp, 32'hBEEF);
        sr_write(32'h13, 4'b0001);
        chk("R5 back to svc", live_sp, 32'h7777);
        bk_read(5'h10, rd, er);
        chk("R5 usr bank", rd, 32'hBEEF);
        bk_read(5'h1F, rd, er);
        chk("R5 sys bank", rd, 32'hBEEF);
        bk_read(5'h11, rd, er);
        chk("R5 fiq bank separate", rd, '0);

        // R6 fast-interrupt register swap
        for (int i = 0; i < 5; i++) lv_write(3'(i), 32'h80 + W'(i));
        chk("R10 r12 write", hi(4), 32'h84);
        sr_write(32'h11, 4'b0001);
        chk("R6 enter fiq r8", hi(0), '0);
        chk("R6 enter fiq r12", hi(4), '0);
        lv_write(3'd0, 32'hF8);
        sr_write(32'h12, 4'b0001);
        chk("R6 leave fiq r8", hi(0), 32'h80);
        chk("R6 leave fiq r12", hi(4), 32'h84);
        chk("R4 irq sp via bank", live_sp, 32'h5555);
        sr_write(32'h13, 4'b0001);
        chk("R6 non-fiq switch r9", hi(1), 32'h81);
        sr_write(32'h11, 4'b0001);
        chk("R6 re-enter fiq r8", hi(0), 32'hF8);
        chk("R6 re-enter fiq r9", hi(1), '0);

        // R9 status write blocks other ports
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = 32'h11; sr_wr_mask = 4'b0010;
        lv_wr_en = 1'b1; lv_wr_sel = 3'd5; lv_wr_data = 32'hDEAD;
        bk_en = 1'b1; bk_we = 1'b1; bk_mode = 5'h11; bk_wdata = 32'h1234;
        @(negedge clk);
        sr_wr_en = 1'b0; lv_wr_en = 1'b0; bk_en = 1'b0; bk_we = 1'b0;
        chk("R9 live sp untouched", live_sp, '0);

        // R3 illegal mode in a wider write
        sr_write(32'h0000AB1D, 4'b0011);
        chk("R3 illegal keeps mode, writes rest", sr_q, 32'h0000AB11);
        chk("R3 no swap on illegal", hi(0), 32'hF8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule